// File: doc/BRIEF.md
# Instruction Bundle Slot Dispatcher

The dispatcher takes one 128-bit instruction bundle at a time over a valid/ready input handshake. It splits the bundle into a 5-bit template and three 41-bit slots. It then hands the slots downstream one per cycle, starting at slot 0. Each issued operation carries an execution-unit code, its slot index, a stop flag and the slot bits. The template selects a kind for each slot and the stop positions, using a built-in table. An extended instruction uses two adjacent slots, a long-immediate slot followed by its extension slot. It leaves as a single operation that carries both slots. That operation is routed to the integer or the branch unit according to the 4-bit major opcode in the extension slot.

A bundle whose template has no table entry is still consumed from the input. It then produces a one-cycle illegal-operation pulse and issues nothing. When the downstream side holds off, the current operation stays frozen. A new bundle can enter in the same cycle that the last operation of the current bundle is taken, so consecutive bundles issue without a gap.

Top module: `bundle_dispatch`

## Requirements
- R1: After reset, `in_ready` is 1, `iss_valid` is 0 and `ill_op` is 0.
- R2: Slot k occupies bundle bits [5+41k +: 41] and the template occupies bits [4:0]. The slots of a legal bundle issue in order 0, 1, 2 with `iss_slot` set to the slot index. `iss_valid` is 1 from the cycle after acceptance until the last operation is taken.
- R3: Unit codes are 0 for memory (M), 1 for integer (I), 2 for floating point (F) and 3 for branch (B). Template 0x00 issues M, I, I with no stop flags. Template 0x10 issues M, I, B with no stop flags.
- R4: Template 0x01 issues M, I, I with `iss_stop` set only on slot 2. Template 0x16 issues B, B, B with no stop flags.
- R5: Template 0x04 issues M on slot 0, then one extended operation with `iss_slot`=1 and `iss_ext`=1. Its `iss_bits[40:0]` holds slot 1 and `iss_bits[81:41]` holds slot 2. Its unit is I when slot 2 bits [40:37] are 0 to 7, and B when they are 8 to 15.
- R6: A non-extended operation has `iss_ext`=0, `iss_bits[40:0]` equal to its slot and `iss_bits[81:41]` equal to zero.
- R7: Any template other than 0x00, 0x01, 0x04, 0x10 and 0x16 (for example 0x06, 0x07 or 0x1F) is reserved. Such a bundle is accepted and drives `ill_op` to 1 for exactly the cycle after acceptance. It produces no `iss_valid`.
- R8: While `iss_valid` is 1 and `iss_ready` is 0, every issue output holds its value.
- R9: While a bundle is in progress, `in_ready` is 0, except in a cycle where its last operation is taken. In that cycle a waiting bundle is accepted, and its first result (slot 0 or fault) appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A bundle is offered |
| in_ready | output | 1 | The offered bundle is taken this cycle |
| in_bundle | input | 128 | Bundle: template in [4:0], slots above it |
| iss_valid | output | 1 | An operation is presented |
| iss_ready | input | 1 | Downstream takes the presented operation |
| iss_unit | output | 3 | Target unit code |
| iss_slot | output | 2 | Index of the (first) slot of the operation |
| iss_stop | output | 1 | A stop follows this operation |
| iss_ext | output | 1 | Operation is a merged extended pair |
| iss_bits | output | 82 | Slot bits; upper half is the extension slot |
| ill_op | output | 1 | One-cycle illegal-operation pulse |

## Verification
The last operation of one bundle being taken and the next bundle being accepted can happen on the same clock edge. The bench provokes this by presenting the next bundle, with `in_valid` held high, while slot 2 is waiting. It does this once with a legal follower and once with a reserved follower. It checks that `in_ready` rises exactly in that cycle. It then checks that the next cycle shows the follower's slot 0, or else the fault pulse with no `iss_valid`. A stall held across several cycles also confirms that `in_ready` stays low mid-bundle.

// File: rtl/bundle_dispatch_pkg.sv
package bundle_dispatch_pkg;
    localparam int SLOT_W   = 41;
    localparam int TMPL_W   = 5;
    localparam int NSLOT    = 3;
    localparam int OPC_W    = 4;
    localparam int UNIT_W   = 3;
    localparam int IDX_W    = $clog2(NSLOT + 1);
    localparam int BUNDLE_W = TMPL_W + NSLOT * SLOT_W;
    localparam int OP_W     = 2 * SLOT_W;

    typedef enum logic [2:0] {
        K_M = 3'd0,
        K_I = 3'd1,
        K_F = 3'd2,
        K_B = 3'd3,
        K_L = 3'd4,
        K_X = 3'd5
    } slot_kind_e;

    localparam logic [UNIT_W-1:0] UNIT_M = 3'd0;
    localparam logic [UNIT_W-1:0] UNIT_I = 3'd1;
    localparam logic [UNIT_W-1:0] UNIT_F = 3'd2;
    localparam logic [UNIT_W-1:0] UNIT_B = 3'd3;

    localparam logic [OPC_W-1:0] OPC_BRANCH_MIN = 4'h8;

    typedef struct packed {
        logic                busy;
        logic [IDX_W-1:0]    idx;
        logic [BUNDLE_W-1:0] bundle;
        logic                fault;
    } seq_state_t;
endpackage

// File: rtl/bd_tmpl_rom.sv
module bd_tmpl_rom
    import bundle_dispatch_pkg::*;
(
    input  logic [TMPL_W-1:0]            tmpl_i,
    output logic                         legal_o,
    output slot_kind_e [NSLOT-1:0]       kind_o,
    output logic [NSLOT-1:0]             stop_o
);
    always_comb begin
        legal_o = 1'b0;
        kind_o  = {NSLOT{K_M}};
        stop_o  = '0;
        case (tmpl_i)
            5'h00: begin
                legal_o   = 1'b1;
                kind_o[0] = K_M;
                kind_o[1] = K_I;
                kind_o[2] = K_I;
            end
            5'h01: begin
                legal_o   = 1'b1;
                kind_o[0] = K_M;
                kind_o[1] = K_I;
                kind_o[2] = K_I;
                stop_o[2] = 1'b1;
            end
            5'h04: begin
                legal_o   = 1'b1;
                kind_o[0] = K_M;
                kind_o[1] = K_L;
                kind_o[2] = K_X;
            end
            5'h10: begin
                legal_o   = 1'b1;
                kind_o[0] = K_M;
                kind_o[1] = K_I;
                kind_o[2] = K_B;
            end
            5'h16: begin
                legal_o   = 1'b1;
                kind_o[0] = K_B;
                kind_o[1] = K_B;
                kind_o[2] = K_B;
            end
            default: begin
                legal_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bd_slot_pick.sv
module bd_slot_pick
    import bundle_dispatch_pkg::*;
(
    input  logic [BUNDLE_W-1:0]          bundle_i,
    input  logic [IDX_W-1:0]             idx_i,
    input  slot_kind_e [NSLOT-1:0]       kind_i,
    input  logic [NSLOT-1:0]             stop_i,
    output logic [UNIT_W-1:0]            unit_o,
    output logic                         ext_o,
    output logic                         stop_o,
    output logic                         last_o,
    output logic [IDX_W-1:0]             nxt_idx_o,
    output logic [OP_W-1:0]              bits_o
);
    logic [SLOT_W-1:0] slot_w [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_split
        assign slot_w[k] = bundle_i[TMPL_W + k*SLOT_W +: SLOT_W];
    end

    function automatic logic [UNIT_W-1:0] kind_to_unit(input slot_kind_e kd);
        case (kd)
            K_M:     return UNIT_M;
            K_I:     return UNIT_I;
            K_F:     return UNIT_F;
            K_B:     return UNIT_B;
            default: return UNIT_I;
        endcase
    endfunction

    always_comb begin
        unit_o    = UNIT_M;
        ext_o     = 1'b0;
        stop_o    = 1'b0;
        last_o    = 1'b1;
        nxt_idx_o = '0;
        bits_o    = '0;
        for (int k = 0; k < NSLOT; k++) begin
            if (idx_i == IDX_W'(k)) begin
                automatic int  xk   = (k + 1 < NSLOT) ? k + 1 : k;
                automatic logic pair = (kind_i[k] == K_L) && (k + 1 < NSLOT)
                                       && (kind_i[xk] == K_X);
                if (pair) begin
                    ext_o     = 1'b1;
                    bits_o    = {slot_w[xk], slot_w[k]};
                    unit_o    = (slot_w[xk][SLOT_W-1 -: OPC_W] >= OPC_BRANCH_MIN)
                                ? UNIT_B : UNIT_I;
                    stop_o    = stop_i[xk];
                    last_o    = (k + 2 >= NSLOT);
                    nxt_idx_o = IDX_W'(k + 2);
                end else begin
                    bits_o    = {{SLOT_W{1'b0}}, slot_w[k]};
                    unit_o    = kind_to_unit(kind_i[k]);
                    stop_o    = stop_i[k];
                    last_o    = (k + 1 >= NSLOT);
                    nxt_idx_o = IDX_W'(k + 1);
                end
            end
        end
    end
endmodule

// File: rtl/bd_seq.sv
module bd_seq
    import bundle_dispatch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    input  logic [BUNDLE_W-1:0] in_bundle_i,
    input  logic                in_legal_i,
    input  logic                iss_ready_i,
    input  logic                cur_last_i,
    input  logic [IDX_W-1:0]    cur_nxt_idx_i,
    output logic                in_ready_o,
    output logic                busy_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [BUNDLE_W-1:0] bundle_o,
    output logic                fault_o
);
    seq_state_t st_d, st_q;
    logic fire_w, done_w, take_w;

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        fire_w     = st_q.busy && iss_ready_i;
        done_w     = fire_w && cur_last_i;
        in_ready_o = !st_q.busy || done_w;
        take_w     = in_valid_i && in_ready_o;
        if (fire_w) begin
            st_d.idx = cur_nxt_idx_i;
        end
        if (done_w) begin
            st_d.busy = 1'b0;
        end
        if (take_w) begin
            st_d.idx    = '0;
            st_d.bundle = in_bundle_i;
            st_d.busy   = in_legal_i;
            st_d.fault  = !in_legal_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign idx_o    = st_q.idx;
    assign bundle_o = st_q.bundle;
    assign fault_o  = st_q.fault;

    AST_FAULT_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(in_valid_i && in_ready_o)) else $error("fault w/o accept"); // R7
    AST_FAULT_ISSUES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !busy_o) else $error("fault with issue"); // R7
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (idx_o < IDX_W'(NSLOT))) else $error("slot index range"); // R2
endmodule

// File: rtl/bundle_dispatch.sv
module bundle_dispatch
    import bundle_dispatch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [127:0]        in_bundle,
    output logic                iss_valid,
    input  logic                iss_ready,
    output logic [2:0]          iss_unit,
    output logic [1:0]          iss_slot,
    output logic                iss_stop,
    output logic                iss_ext,
    output logic [81:0]         iss_bits,
    output logic                ill_op
);
    logic                   in_legal_w, cur_legal_w;
    slot_kind_e [NSLOT-1:0] in_kind_w, cur_kind_w;
    logic [NSLOT-1:0]       in_stop_w, cur_stop_w;
    logic                   busy_w, last_w;
    logic [IDX_W-1:0]       idx_w, nxt_idx_w;
    logic [BUNDLE_W-1:0]    bundle_w;

    bd_tmpl_rom u_in_rom (
        .tmpl_i  (in_bundle[TMPL_W-1:0]),
        .legal_o (in_legal_w),
        .kind_o  (in_kind_w),
        .stop_o  (in_stop_w)
    );

    bd_tmpl_rom u_cur_rom (
        .tmpl_i  (bundle_w[TMPL_W-1:0]),
        .legal_o (cur_legal_w),
        .kind_o  (cur_kind_w),
        .stop_o  (cur_stop_w)
    );

    bd_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid_i    (in_valid),
        .in_bundle_i   (in_bundle),
        .in_legal_i    (in_legal_w),
        .iss_ready_i   (iss_ready),
        .cur_last_i    (last_w),
        .cur_nxt_idx_i (nxt_idx_w),
        .in_ready_o    (in_ready),
        .busy_o        (busy_w),
        .idx_o         (idx_w),
        .bundle_o      (bundle_w),
        .fault_o       (ill_op)
    );

    bd_slot_pick u_pick (
        .bundle_i  (bundle_w),
        .idx_i     (idx_w),
        .kind_i    (cur_kind_w),
        .stop_i    (cur_stop_w),
        .unit_o    (iss_unit),
        .ext_o     (iss_ext),
        .stop_o    (iss_stop),
        .last_o    (last_w),
        .nxt_idx_o (nxt_idx_w),
        .bits_o    (iss_bits)
    );

    assign iss_valid = busy_w;
    assign iss_slot  = idx_w;

    AST_STORED_TMPL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> cur_legal_w) else $error("reserved template issued"); // R7
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_bits) && $stable(iss_unit)
            && $stable(iss_slot) && $stable(iss_stop) && $stable(iss_ext)))
        else $error("stall not held"); // R8
    AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !last_w && !iss_ext) |=>
            (iss_valid && iss_slot == $past(iss_slot) + 2'd1)) else $error("slot order"); // R2
    AST_EXT_PAIR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ext) |-> (iss_slot == 2'd1 && (iss_unit == UNIT_I || iss_unit == UNIT_B)))
        else $error("extended op shape"); // R5
    AST_PLAIN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ext) |-> (iss_bits[OP_W-1:SLOT_W] == '0))
        else $error("plain op upper bits"); // R6
    AST_NO_MIDBUNDLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |-> !in_ready) else $error("accept mid-bundle"); // R9
endmodule

// File: tb/bundle_dispatch_tb.sv
module bundle_dispatch_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_bundle = '0;
    logic         iss_valid;
    logic         iss_ready = 1'b1;
    logic [2:0]   iss_unit;
    logic [1:0]   iss_slot;
    logic         iss_stop;
    logic         iss_ext;
    logic [81:0]  iss_bits;
    logic         ill_op;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    bundle_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bundle(in_bundle), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_unit(iss_unit), .iss_slot(iss_slot), .iss_stop(iss_stop),
        .iss_ext(iss_ext), .iss_bits(iss_bits), .ill_op(ill_op)
    );

    localparam logic [40:0] SA = 41'h0A5_1234_5678;
    localparam logic [40:0] SB = 41'h15A_9ABC_DEF0;
    localparam logic [40:0] SC = 41'h0F0_0F0F_3C3C;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(input logic [4:0] t, input logic [40:0] s0,
                                        input logic [40:0] s1, input logic [40:0] s2);
        return {s2, s1, s0, t};
    endfunction

    task automatic accept(input logic [127:0] b, input string req);
        in_bundle = b;
        in_valid  = 1'b1;
        chk(in_ready === 1'b1, req, "in_ready idle", 128'(in_ready), 128'd1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_op(input logic [1:0] idx, input logic [2:0] unit, input logic stop,
                             input logic ext, input logic [81:0] bits, input string req);
        chk(iss_valid === 1'b1, req, "iss_valid", 128'(iss_valid), 128'd1);
        chk(iss_slot === idx, req, "iss_slot", 128'(iss_slot), 128'(idx));
        chk(iss_unit === unit, req, "iss_unit", 128'(iss_unit), 128'(unit));
        chk(iss_stop === stop, req, "iss_stop", 128'(iss_stop), 128'(stop));
        chk(iss_ext === ext, req, "iss_ext", 128'(iss_ext), 128'(ext));
        chk(iss_bits === bits, req, "iss_bits", 128'(iss_bits), 128'(bits));
        @(negedge clk);
    endtask

    task automatic expect_idle(input string req);
        chk(iss_valid === 1'b0, req, "idle iss_valid", 128'(iss_valid), 128'd0);
        chk(ill_op === 1'b0, req, "idle ill_op", 128'(ill_op), 128'd0);
    endtask

    task automatic t_reset();
        chk(in_ready === 1'b1, "R1", "reset in_ready", 128'(in_ready), 128'd1);
        expect_idle("R1");
    endtask

    task automatic t_mii();
        accept(mk(5'h00, SA, SB, SC), "R3");
        expect_op(2'd0, 3'd0, 1'b0, 1'b0, {41'd0, SA}, "R2");
        expect_op(2'd1, 3'd1, 1'b0, 1'b0, {41'd0, SB}, "R3");
        expect_op(2'd2, 3'd1, 1'b0, 1'b0, {41'd0, SC}, "R6");
        expect_idle("R2");
    endtask

    task automatic t_mii_stop();
        accept(mk(5'h01, SC, SA, SB), "R4");
        expect_op(2'd0, 3'd0, 1'b0, 1'b0, {41'd0, SC}, "R4");
        expect_op(2'd1, 3'd1, 1'b0, 1'b0, {41'd0, SA}, "R4");
        expect_op(2'd2, 3'd1, 1'b1, 1'b0, {41'd0, SB}, "R4");
        expect_idle("R4");
    endtask

    task automatic t_mib();
        accept(mk(5'h10, SB, SC, SA), "R3");
        expect_op(2'd0, 3'd0, 1'b0, 1'b0, {41'd0, SB}, "R3");
        expect_op(2'd1, 3'd1, 1'b0, 1'b0, {41'd0, SC}, "R3");
        expect_op(2'd2, 3'd3, 1'b0, 1'b0, {41'd0, SA}, "R3");
        expect_idle("R3");
    endtask

    task automatic t_bbb();
        accept(mk(5'h16, SA, SC, SB), "R4");
        expect_op(2'd0, 3'd3, 1'b0, 1'b0, {41'd0, SA}, "R4");
        expect_op(2'd1, 3'd3, 1'b0, 1'b0, {41'd0, SC}, "R4");
        expect_op(2'd2, 3'd3, 1'b0, 1'b0, {41'd0, SB}, "R4");
        expect_idle("R4");
    endtask

    task automatic t_mlx(input logic [3:0] opc);
        logic [40:0] xs;
        logic [2:0]  eu;
        xs = {opc, SC[36:0]};
        eu = (opc >= 4'h8) ? 3'd3 : 3'd1;
        accept(mk(5'h04, SA, SB, xs), "R5");
        expect_op(2'd0, 3'd0, 1'b0, 1'b0, {41'd0, SA}, "R5");
        expect_op(2'd1, eu, 1'b0, 1'b1, {xs, SB}, "R5");
        expect_idle("R5");
    endtask

    task automatic t_reserved(input logic [4:0] t);
        accept(mk(t, SA, SB, SC), "R7");
        chk(ill_op === 1'b1, "R7", "ill_op pulse", 128'(ill_op), 128'd1);
        chk(iss_valid === 1'b0, "R7", "no issue on fault", 128'(iss_valid), 128'd0);
        @(negedge clk);
        chk(ill_op === 1'b0, "R7", "ill_op one cycle", 128'(ill_op), 128'd0);
        chk(iss_valid === 1'b0, "R7", "still no issue", 128'(iss_valid), 128'd0);
    endtask

    task automatic t_backpressure();
        accept(mk(5'h16, SB, SA, SC), "R8");
        iss_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(iss_valid === 1'b1 && iss_slot === 2'd0, "R8", "held slot",
                128'(iss_slot), 128'd0);
            chk(iss_bits === {41'd0, SB}, "R8", "held bits", 128'(iss_bits), 128'(SB));
            chk(in_ready === 1'b0, "R9", "in_ready mid-bundle", 128'(in_ready), 128'd0);
        end
        iss_ready = 1'b1;
        expect_op(2'd0, 3'd3, 1'b0, 1'b0, {41'd0, SB}, "R8");
        chk(in_ready === 1'b0, "R9", "in_ready slot1", 128'(in_ready), 128'd0);
        expect_op(2'd1, 3'd3, 1'b0, 1'b0, {41'd0, SA}, "R8");
        expect_op(2'd2, 3'd3, 1'b0, 1'b0, {41'd0, SC}, "R8");
        expect_idle("R8");
    endtask

    task automatic t_handoff();
        accept(mk(5'h00, SA, SB, SC), "R9");
        expect_op(2'd0, 3'd0, 1'b0, 1'b0, {41'd0, SA}, "R9");
        expect_op(2'd1, 3'd1, 1'b0, 1'b0, {41'd0, SB}, "R9");
        in_bundle = mk(5'h10, SC, SA, SB);
        in_valid  = 1'b1;
        chk(in_ready === 1'b1, "R9", "in_ready at last slot", 128'(in_ready), 128'd1);
        expect_op(2'd2, 3'd1, 1'b0, 1'b0, {41'd0, SC}, "R9");
        in_valid = 1'b0;
        expect_op(2'd0, 3'd0, 1'b0, 1'b0, {41'd0, SC}, "R9");
        expect_op(2'd1, 3'd1, 1'b0, 1'b0, {41'd0, SA}, "R9");
        in_bundle = mk(5'h07, SA, SA, SA);
        in_valid  = 1'b1;
        chk(in_ready === 1'b1, "R9", "in_ready before fault", 128'(in_ready), 128'd1);
        expect_op(2'd2, 3'd3, 1'b0, 1'b0, {41'd0, SB}, "R9");
        in_valid = 1'b0;
        chk(ill_op === 1'b1, "R7", "fault after handoff", 128'(ill_op), 128'd1);
        chk(iss_valid === 1'b0, "R7", "no issue after handoff", 128'(iss_valid), 128'd0);
        @(negedge clk);
        expect_idle("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mii();
        t_mii_stop();
        t_mib();
        t_bbb();
        t_mlx(4'h5);
        t_mlx(4'h7);
        t_mlx(4'h8);
        t_mlx(4'hC);
        t_reserved(5'h06);
        t_reserved(5'h07);
        t_reserved(5'h1F);
        t_backpressure();
        t_handoff();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule